// File: doc/BRIEF.md
# Multi-drop serial transmitter with idle guard

This block serialises 8-bit characters onto a single line that rests high. Every frame is one low start bit, eight data bits with the least significant bit first, a ninth bit, and one high stop bit. Each bit lasts from one baud tick to the next. The baud tick comes from outside the block. A one-character holding register feeds the shift register, so software can queue the next character while the current one is on the line.

When the three-bit parity mode selects multi-drop operation, the ninth bit tells listeners whether the character is an address (1) or data (0). A send-address strobe marks the next accepted character as an address. After each frame the block can keep the line high for a programmable number of extra bit periods. The controller uses this guard to pace slow listeners. The guard counts as part of the current character, so both the ready flag and the empty flag are delayed by it.

Top module: `mdrop_tx`

## Requirements
- R1: While reset is held and right after it is released, the line is high (1) and both tx_ready and tx_empty are 1.
- R2: A frame is a 0 start bit, then data bits 0 to 7 in that order, then the ninth bit, then a 1 stop bit. Each bit lasts exactly one interval between baud ticks.
- R3: Multi-drop operation applies only when par_mode is 3'd6 or 3'd7. In any other mode the ninth bit is always 0. The mode is sampled when the character is accepted.
- R4: In multi-drop mode, a send_addr strobe gives the ninth bit the value 1 for the next accepted character only. A strobe in the same cycle as the accepted write also applies to that write.
- R5: A character accepted with no pending address request has a ninth bit of 0. A second strobe before the consuming write adds nothing, so only one character is marked.
- R6: With guard_len equal to 0, the next start bit begins at the tick that ends the stop bit. With guard_len equal to G (1 to 255), the line stays high for G further bit periods before the next start bit.
- R7: tx_ready is low from the cycle after an accepted write until the cycle in which that character's start bit appears on the line. It stays low through the whole guard interval when a character is waiting.
- R8: tx_empty is 1 only when no character is waiting and no frame or guard interval is in progress. While tx_empty is 1, the line is high.
- R9: A write while tx_ready is 0 is ignored. Its data is never sent, and it does not consume a pending address request.
- R10: When the block is idle, a character accepted at one clock edge begins its start bit at the first later edge that has the baud tick high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse at each bit boundary |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 8 | Character to send |
| send_addr | input | 1 | Marks the next accepted character as an address |
| par_mode | input | 3 | Ninth-bit mode; 6 or 7 selects multi-drop |
| guard_len | input | 8 | Extra idle bit periods after each stop bit |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing waiting and nothing on the line |

## Verification
An accepted write drops tx_ready one clock later. The start bit then appears at the first later edge that has bit_tick high. Each following bit and each guard period moves on only at a tick edge, and tx_ready rises in the same cycle that the start bit begins. The bench keeps a behavioural model of the line as a queue of pending bit levels. The model advances at the same edges, and the bench compares txd, tx_ready and tx_empty against it at every falling edge, after all register updates have settled. Directed scenarios cover the cases where the due cycle is tricky: back-to-back frames with and without a guard, a guard of 255, writes refused while a character waits, and address strobes that come before or with the write.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MARK,
    ST_STOP,
    ST_GUARD
  } tx_state_e;

  // multi-drop is selected by mode values 6 and 7
  function automatic logic is_multidrop(input logic [2:0] mode);
    return mode[2] & mode[1];
  endfunction

  // ninth-bit value for a character accepted now
  function automatic logic ninth_bit(input logic [2:0] mode, input logic pend, input logic strobe);
    return is_multidrop(mode) & (pend | strobe);
  endfunction

  // guard count loaded at stop end: periods remaining after the first
  function automatic logic [7:0] guard_start(input logic [7:0] g);
    return g - 8'd1;
  endfunction

endpackage

// File: rtl/mdrop_hold.sv
module mdrop_hold
  import mdrop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          send_addr_i,
  input  logic [2:0]    mode_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          mark_o
);

  logic          full_q;
  logic [DW-1:0] data_q;
  logic          mark_q;
  logic          addr_pend_q;
  logic          wr_acc;

  assign wr_acc = wr_i & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q      <= 1'b0;
      data_q      <= '0;
      mark_q      <= 1'b0;
      addr_pend_q <= 1'b0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (wr_acc) begin
        full_q <= 1'b1;
        data_q <= data_i;
        mark_q <= ninth_bit(mode_i, addr_pend_q, send_addr_i);
      end
      if (wr_acc) addr_pend_q <= 1'b0;
      else if (send_addr_i) addr_pend_q <= 1'b1;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign mark_o = mark_q;

  // R9: a refused write leaves the waiting character untouched
  p_refused_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take_i && wr_i) |=> (full_q && $stable(data_q)));

  // R3: outside multi-drop the stored ninth bit is 0
  p_mark_needs_md_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !is_multidrop(mode_i)) |=> !mark_q);

endmodule

// File: rtl/mdrop_shifter.sv
module mdrop_shifter
  import mdrop_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          hold_full_i,
  input  logic [DW-1:0] hold_data_i,
  input  logic          hold_mark_i,
  input  logic [GW-1:0] guard_i,
  output logic          load_o,
  output logic          txd_o,
  output logic          idle_o
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  tx_state_e     state_q;
  logic [DW-1:0] sh_q;
  logic          mark_q;
  logic [CW-1:0] bcnt_q;
  logic [GW-1:0] gcnt_q;
  logic          frame_last;

  assign frame_last = (state_q == ST_STOP && guard_i == '0) ||
                      (state_q == ST_GUARD && gcnt_q == '0);
  assign load_o = tick_i & hold_full_i & ((state_q == ST_IDLE) | frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      mark_q  <= 1'b0;
      bcnt_q  <= '0;
      gcnt_q  <= '0;
    end else if (load_o) begin
      state_q <= ST_START;
      sh_q    <= hold_data_i;
      mark_q  <= hold_mark_i;
    end else if (tick_i) begin
      case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          bcnt_q  <= '0;
        end
        ST_DATA: begin
          sh_q <= sh_q >> 1;
          if (bcnt_q == CW'(DW - 1)) state_q <= ST_MARK;
          else bcnt_q <= bcnt_q + 1'b1;
        end
        ST_MARK: state_q <= ST_STOP;
        ST_STOP: begin
          if (guard_i == '0) state_q <= ST_IDLE;
          else begin
            state_q <= ST_GUARD;
            gcnt_q  <= GW'(guard_start(8'(guard_i)));
          end
        end
        ST_GUARD: begin
          if (gcnt_q == '0) state_q <= ST_IDLE;
          else gcnt_q <= gcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_MARK:  txd_o = mark_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign idle_o = (state_q == ST_IDLE);

  // R6: the guard count only moves on a baud tick
  p_guard_waits_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GUARD && !tick_i) |=> (state_q == ST_GUARD && $stable(gcnt_q)));

endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
  import mdrop_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          hold_wr,
  input  logic [DW-1:0] hold_data,
  input  logic          send_addr,
  input  logic [2:0]    par_mode,
  input  logic [GW-1:0] guard_len,
  output logic          txd,
  output logic          tx_ready,
  output logic          tx_empty
);

  logic          load_w;
  logic          full_w;
  logic [DW-1:0] hdata_w;
  logic          hmark_w;
  logic          idle_w;

  mdrop_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_i(hold_wr), .data_i(hold_data),
    .send_addr_i(send_addr), .mode_i(par_mode), .take_i(load_w),
    .full_o(full_w), .data_o(hdata_w), .mark_o(hmark_w)
  );

  mdrop_shifter #(.DW(DW), .GW(GW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(bit_tick), .hold_full_i(full_w),
    .hold_data_i(hdata_w), .hold_mark_i(hmark_w), .guard_i(guard_len),
    .load_o(load_w), .txd_o(txd), .idle_o(idle_w)
  );

  assign tx_ready = ~full_w;
  assign tx_empty = idle_w & ~full_w;

  // R2: the cycle after a load shows the start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> !txd);

  // R7: ready rises only as a start bit begins
  p_ready_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(load_w));

  // R8: empty implies an idle high line and a free holding register
  p_empty_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && tx_ready));

endmodule

// File: tb/test_mdrop_tx.sv
module test_mdrop_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       hold_wr = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic       send_addr = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic [7:0] guard_len = 8'd0;
  logic       txd, tx_ready, tx_empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  mdrop_tx i_mdrop_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hold_wr(hold_wr),
    .hold_data(hold_data), .send_addr(send_addr), .par_mode(par_mode),
    .guard_len(guard_len), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  // ---------------- behavioural reference ----------------
  int   line_q[$];
  bit   m_pend_valid;
  bit   [7:0] m_pend_data;
  bit   m_pend_mark;
  bit   m_addr_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      line_q.delete();
      m_pend_valid = 0;
      m_pend_mark  = 0;
      m_addr_req   = 0;
    end else begin
      bit was_full;
      was_full = m_pend_valid;
      if (bit_tick) begin
        if (line_q.size() > 0) void'(line_q.pop_front());
        if (line_q.size() == 0 && m_pend_valid) begin
          line_q.push_back(0);
          for (int i = 0; i < 8; i++) line_q.push_back(int'(m_pend_data[i]));
          line_q.push_back(int'(m_pend_mark));
          line_q.push_back(1);
          for (int g = 0; g < int'(guard_len); g++) line_q.push_back(1);
          m_pend_valid = 0;
        end
      end
      if (hold_wr && !was_full) begin
        m_pend_valid = 1;
        m_pend_data  = hold_data;
        m_pend_mark  = (par_mode == 3'd6 || par_mode == 3'd7) && (m_addr_req || send_addr);
        m_addr_req   = 0;
      end else if (send_addr) begin
        m_addr_req = 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "txd", int'(txd), (line_q.size() > 0) ? line_q[0] : 1);
      check(cur_req, "tx_ready", int'(tx_ready), int'(!m_pend_valid));
      check(cur_req, "tx_empty", int'(tx_empty), int'(!m_pend_valid && line_q.size() == 0));
    end
  end

  // baud tick every fourth clock
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 4;
      bit_tick = (cnt == 3);
    end
  end

  task automatic wr(input logic [7:0] d, input logic addr);
    @(negedge clk);
    hold_wr = 1'b1; hold_data = d; send_addr = addr;
    @(negedge clk);
    hold_wr = 1'b0; send_addr = 1'b0;
  endtask

  task automatic strobe_addr();
    @(negedge clk);
    send_addr = 1'b1;
    @(negedge clk);
    send_addr = 1'b0;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic wait_empty();
    repeat (2) @(negedge clk);
    while (!tx_empty) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "txd in reset", int'(txd), 1);
    check("R1", "ready in reset", int'(tx_ready), 1);
    check("R1", "empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", int'(tx_ready), 1);

    // R2 / R10: plain frame, guard off
    cur_req = "R2_R10";
    wr(8'hA5, 1'b0);
    wait_empty();

    // R3 / R4: multi-drop, address then data
    cur_req = "R4";
    par_mode = 3'd6;
    strobe_addr();
    wr(8'h3C, 1'b0);
    cur_req = "R5";
    wait_ready();
    wr(8'h55, 1'b0);
    wait_empty();

    // R4: strobe in the same cycle as the write, mode 7
    cur_req = "R4";
    par_mode = 3'd7;
    wr(8'hC3, 1'b1);
    wait_empty();

    // R5: double strobe marks one character only
    cur_req = "R5";
    strobe_addr();
    strobe_addr();
    wr(8'h0F, 1'b0);
    wait_ready();
    wr(8'hF0, 1'b0);
    wait_empty();

    // R3: not multi-drop, strobe has no visible effect
    cur_req = "R3";
    par_mode = 3'd2;
    wr(8'h81, 1'b1);
    wait_empty();

    // R6 / R7: guard of 3 with back-to-back characters
    cur_req = "R6_R7";
    par_mode = 3'd6;
    guard_len = 8'd3;
    wr(8'h11, 1'b0);
    wait_ready();
    wr(8'h22, 1'b1);
    wait_ready();
    wr(8'h33, 1'b0);
    wait_empty();

    // R6: back-to-back with guard zero
    cur_req = "R6";
    guard_len = 8'd0;
    wr(8'h44, 1'b0);
    wait_ready();
    wr(8'h66, 1'b0);
    wait_empty();

    // R9: refused write, pending address request survives
    cur_req = "R9";
    wr(8'h77, 1'b0);
    wait_ready();
    wr(8'h88, 1'b0);
    strobe_addr();
    wr(8'h99, 1'b0);
    check("R9", "ready stays low after refused write", int'(tx_ready), 0);
    wait_ready();
    wr(8'hAA, 1'b0);
    wait_empty();

    // R6 / R8: longest guard
    cur_req = "R6_R8";
    guard_len = 8'd255;
    wr(8'h5A, 1'b0);
    wait_ready();
    wr(8'hA6, 1'b0);
    wait_empty();
    guard_len = 8'd0;
    cur_req = "R8";
    repeat (10) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule